// File: doc/BRIEF.md
# Region Protection and Translation Unit

This unit divides a 32-bit virtual address space into eight equal regions of 512 MB. The three most significant address bits select the region. Each region has a small entry with two fields: a physical region number, which is the top bits of the translated address, and a 4-bit protection attribute. The unit keeps two separate tables. Instruction fetches look up the instruction table. Loads and stores look up the data table.

For each access the caller presents the address and two flags. One flag marks an instruction fetch. The other marks a store; it applies only when the access is not a fetch. The unit returns the translated address at once, or raises a fault with a cause code that depends on the access kind. Each table has its own write port, which takes a region index, a physical region number and an attribute. The lookup path is purely combinational. A table write takes effect on the clock edge, so the new entry is seen on the cycle after the write is presented.

Top module: `rpu_top`

## Requirements
- R1: The region index is address bits [31:29]. A lookup reads only the entry of that region, and changing one region's entry leaves the translation of every other region unchanged.
- R2: On a granted access, `pa_out` equals the entry's 3-bit physical region number in bits [31:29], with bits [28:0] copied from `acc_addr[28:0]`.
- R3: Loads and stores are granted when the attribute is 0, 1, 2, 4, 5 or 14. They are denied for every other attribute value.
- R4: Instruction fetches are granted when the attribute is in the range 1 to 5 inclusive. They are denied for every other attribute value.
- R5: After a synchronous reset, in both tables, region i has physical region number i and attribute 2. Every address therefore maps to itself, and reads, writes and fetches are all granted.
- R6: `cause` uses this encoding: 0 means no fault, 1 means a denied load, 2 means a denied store, 3 means a denied fetch. `fault` is high exactly when `cause` is not 0.
- R7: Fetches (`acc_fetch`=1) use only the instruction table, and all other accesses use only the data table. A write to one table does not change results that come from the other table.
- R8: A write presented with its enable high is not seen by a lookup in the same cycle. It is seen by lookups from the cycle after the clock edge that captures it.
- R9: While `fault` is high, `pa_out` is zero.
- R10: `acc_write` has no effect on the result of a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 32 | Virtual address of the access |
| acc_fetch | input | 1 | 1 = instruction fetch |
| acc_write | input | 1 | 1 = store, 0 = load (used only when not a fetch) |
| itab_wr_en | input | 1 | Instruction table write enable |
| itab_wr_idx | input | 3 | Instruction table region to write |
| itab_wr_base | input | 3 | Physical region number to store |
| itab_wr_attr | input | 4 | Attribute to store |
| dtab_wr_en | input | 1 | Data table write enable |
| dtab_wr_idx | input | 3 | Data table region to write |
| dtab_wr_base | input | 3 | Physical region number to store |
| dtab_wr_attr | input | 4 | Attribute to store |
| pa_out | output | 32 | Translated address, zero on fault |
| fault | output | 1 | Access denied |
| cause | output | 2 | Fault cause code (see R6) |

## Verification
The hardest case to reach from the ports is a lookup of a region in the same cycle that its entry is being rewritten. The stimulus raises the write enable and presents a matching lookup in the same low clock phase. It samples the old translation before the edge, and then samples the new translation just after the edge. The attribute decode is not monotonic, so the stimulus walks all sixteen attribute values through one region of each table. It checks every access kind against the expected grant, and it runs fetches with the store flag both low and high.

// File: rtl/rpu_pkg.sv
package rpu_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_LOAD  = 2'd1,
    CAUSE_STORE = 2'd2,
    CAUSE_FETCH = 2'd3
  } fault_cause_e;

  typedef struct packed {
    logic data_ok;
    logic exec_ok;
  } rights_t;
endpackage

// File: rtl/rpu_region_table.sv
module rpu_region_table #(
  parameter int IDX_W      = 3,
  parameter int ATTR_W     = 4,
  parameter int RESET_ATTR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_base,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rd_base,
  output logic [ATTR_W-1:0] rd_attr
);
  localparam int NREG = 1 << IDX_W;

  logic [IDX_W-1:0]  base_q [NREG];
  logic [ATTR_W-1:0] attr_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= IDX_W'(g);
        attr_q[g] <= ATTR_W'(RESET_ATTR);
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        base_q[g] <= wr_base;
        attr_q[g] <= wr_attr;
      end
    end
  end

  assign rd_base = base_q[rd_idx];
  assign rd_attr = attr_q[rd_idx];

  // R8
  table_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (attr_q[$past(wr_idx)] == $past(wr_attr)) &&
              (base_q[$past(wr_idx)] == $past(wr_base)));
endmodule

// File: rtl/rpu_rights_decode.sv
module rpu_rights_decode #(
  parameter int ATTR_W = 4
) (
  input  logic [ATTR_W-1:0] attr,
  output rpu_pkg::rights_t  rights
);
  always_comb begin
    rights.data_ok = ((attr < ATTR_W'(6)) && (attr != ATTR_W'(3))) ||
                     (attr == ATTR_W'(14));
    rights.exec_ok = (attr >= ATTR_W'(1)) && (attr <= ATTR_W'(5));
  end
endmodule

// File: rtl/rpu_top.sv
module rpu_top #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 3,
  parameter int ATTR_W     = 4,
  parameter int RESET_ATTR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_fetch,
  input  logic              acc_write,
  input  logic              itab_wr_en,
  input  logic [IDX_W-1:0]  itab_wr_idx,
  input  logic [IDX_W-1:0]  itab_wr_base,
  input  logic [ATTR_W-1:0] itab_wr_attr,
  input  logic              dtab_wr_en,
  input  logic [IDX_W-1:0]  dtab_wr_idx,
  input  logic [IDX_W-1:0]  dtab_wr_base,
  input  logic [ATTR_W-1:0] dtab_wr_attr,
  output logic [ADDR_W-1:0] pa_out,
  output logic              fault,
  output logic [1:0]        cause
);
  import rpu_pkg::*;

  localparam int OFS_W  = ADDR_W - IDX_W;
  localparam int NTAB   = 2;
  localparam int SIDE_I = 0;
  localparam int SIDE_D = 1;

  logic              wen   [NTAB];
  logic [IDX_W-1:0]  widx  [NTAB];
  logic [IDX_W-1:0]  wbase [NTAB];
  logic [ATTR_W-1:0] wattr [NTAB];
  logic [IDX_W-1:0]  tbase [NTAB];
  logic [ATTR_W-1:0] tattr [NTAB];

  assign wen[SIDE_I]   = itab_wr_en;
  assign widx[SIDE_I]  = itab_wr_idx;
  assign wbase[SIDE_I] = itab_wr_base;
  assign wattr[SIDE_I] = itab_wr_attr;
  assign wen[SIDE_D]   = dtab_wr_en;
  assign widx[SIDE_D]  = dtab_wr_idx;
  assign wbase[SIDE_D] = dtab_wr_base;
  assign wattr[SIDE_D] = dtab_wr_attr;

  logic [IDX_W-1:0] region;
  assign region = acc_addr[ADDR_W-1:OFS_W];

  for (genvar s = 0; s < NTAB; s++) begin : g_side
    rpu_region_table #(
      .IDX_W(IDX_W), .ATTR_W(ATTR_W), .RESET_ATTR(RESET_ATTR)
    ) u_tab (
      .clk(clk), .rst(rst),
      .wr_en(wen[s]), .wr_idx(widx[s]), .wr_base(wbase[s]), .wr_attr(wattr[s]),
      .rd_idx(region), .rd_base(tbase[s]), .rd_attr(tattr[s])
    );
  end

  logic [IDX_W-1:0]  sel_base;
  logic [ATTR_W-1:0] sel_attr;
  rights_t           rights;

  assign sel_base = acc_fetch ? tbase[SIDE_I] : tbase[SIDE_D];
  assign sel_attr = acc_fetch ? tattr[SIDE_I] : tattr[SIDE_D];

  rpu_rights_decode #(.ATTR_W(ATTR_W)) u_dec (.attr(sel_attr), .rights(rights));

  fault_cause_e cause_c;
  always_comb begin
    cause_c = CAUSE_NONE;
    if (acc_fetch) begin
      if (!rights.exec_ok) cause_c = CAUSE_FETCH;
    end else if (!rights.data_ok) begin
      cause_c = acc_write ? CAUSE_STORE : CAUSE_LOAD;
    end
  end

  assign fault  = (cause_c != CAUSE_NONE);
  assign cause  = cause_c;
  assign pa_out = fault ? '0 : {sel_base, acc_addr[OFS_W-1:0]};

  // R6
  fetch_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (fault && acc_fetch) |-> (cause == CAUSE_FETCH));

  // R6
  store_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (fault && !acc_fetch && acc_write) |-> (cause == CAUSE_STORE));

  // R9
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> (pa_out == '0));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !fault |-> (pa_out[OFS_W-1:0] == acc_addr[OFS_W-1:0]));
endmodule

// File: tb/tb_rpu_top.sv
`timescale 1ns/1ps
module tb_rpu_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] acc_addr;
  logic        acc_fetch, acc_write;
  logic        itab_wr_en, dtab_wr_en;
  logic [2:0]  itab_wr_idx, itab_wr_base, dtab_wr_idx, dtab_wr_base;
  logic [3:0]  itab_wr_attr, dtab_wr_attr;
  logic [31:0] pa_out;
  logic        fault;
  logic [1:0]  cause;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rpu_top dut (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_fetch(acc_fetch), .acc_write(acc_write),
    .itab_wr_en(itab_wr_en), .itab_wr_idx(itab_wr_idx), .itab_wr_base(itab_wr_base),
    .itab_wr_attr(itab_wr_attr), .dtab_wr_en(dtab_wr_en), .dtab_wr_idx(dtab_wr_idx),
    .dtab_wr_base(dtab_wr_base), .dtab_wr_attr(dtab_wr_attr),
    .pa_out(pa_out), .fault(fault), .cause(cause)
  );

  function automatic bit data_ok(input int a);
    return ((a < 6) && (a != 3)) || (a == 14);
  endfunction

  function automatic bit exec_ok(input int a);
    return (a >= 1) && (a <= 5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present a lookup in the low phase and sample 1 ns later.
  task automatic look(input logic [31:0] a, input bit f, input bit w);
    @(negedge clk);
    acc_addr = a; acc_fetch = f; acc_write = w;
    #1;
  endtask

  task automatic wr_tab(input bit itab, input int idx, input int base, input int attr);
    @(negedge clk);
    if (itab) begin
      itab_wr_en = 1; itab_wr_idx = 3'(idx); itab_wr_base = 3'(base); itab_wr_attr = 4'(attr);
    end else begin
      dtab_wr_en = 1; dtab_wr_idx = 3'(idx); dtab_wr_base = 3'(base); dtab_wr_attr = 4'(attr);
    end
    @(negedge clk);
    itab_wr_en = 0; dtab_wr_en = 0;
  endtask

  task automatic t_reset_map();
    for (int r = 0; r < 8; r++) begin
      logic [31:0] a;
      a = {3'(r), 29'h0ABCDE1};
      look(a, 0, 0);
      check(!fault && pa_out == a, "R5 reset data read identity", pa_out, a);
      look(a, 0, 1);
      check(!fault && pa_out == a, "R5 reset data write identity", pa_out, a);
      look(a, 1, 0);
      check(!fault && pa_out == a, "R5 reset fetch identity", pa_out, a);
    end
  endtask

  task automatic t_write_timing();
    logic [31:0] a;
    a = {3'd1, 29'h0000_0F0};
    @(negedge clk);
    dtab_wr_en = 1; dtab_wr_idx = 3'd1; dtab_wr_base = 3'd7; dtab_wr_attr = 4'd2;
    acc_addr = a; acc_fetch = 0; acc_write = 0;
    #1;
    check(pa_out == a, "R8 write not seen same cycle", pa_out, a);
    @(posedge clk);
    #1;
    check(pa_out == {3'd7, a[28:0]}, "R8 write seen next cycle", pa_out, {3'd7, a[28:0]});
    @(negedge clk);
    dtab_wr_en = 0;
  endtask

  task automatic t_remap_and_sides();
    logic [31:0] a2, a3;
    a2 = {3'd2, 29'h1234567};
    a3 = {3'd3, 29'h1234567};
    wr_tab(0, 2, 6, 0);
    look(a2, 0, 1);
    check(!fault && pa_out == {3'd6, a2[28:0]}, "R2 remapped translation", pa_out, {3'd6, a2[28:0]});
    look(a3, 0, 0);
    check(pa_out == a3, "R1 neighbour region unchanged", pa_out, a3);
    look(a2, 1, 0);
    check(!fault && pa_out == a2, "R7 fetch ignores data table", pa_out, a2);
    wr_tab(1, 4, 0, 3);
    look({3'd4, 29'h55}, 0, 1);
    check(!fault && pa_out == {3'd4, 29'h55}, "R7 data ignores instruction table", pa_out, {3'd4, 29'h55});
    look({3'd4, 29'h55}, 1, 0);
    check(!fault && pa_out == {3'd0, 29'h55}, "R7 fetch uses instruction table", pa_out, {3'd0, 29'h55});
  endtask

  task automatic t_attr_sweep();
    logic [31:0] a;
    a = {3'd5, 29'h0C0FFEE};
    for (int at = 0; at < 16; at++) begin
      wr_tab(0, 5, 5, at);
      wr_tab(1, 5, 5, at);
      look(a, 0, 0);
      check((fault == !data_ok(at)) && (cause == (data_ok(at) ? 2'd0 : 2'd1)),
            $sformatf("R3 R6 load attr %0d", at), {29'd0, fault, cause}, {29'd0, !data_ok(at), data_ok(at) ? 2'd0 : 2'd1});
      look(a, 0, 1);
      check((fault == !data_ok(at)) && (cause == (data_ok(at) ? 2'd0 : 2'd2)),
            $sformatf("R3 R6 store attr %0d", at), {29'd0, fault, cause}, {29'd0, !data_ok(at), data_ok(at) ? 2'd0 : 2'd2});
      look(a, 1, 0);
      check((fault == !exec_ok(at)) && (cause == (exec_ok(at) ? 2'd0 : 2'd3)),
            $sformatf("R4 R6 fetch attr %0d", at), {29'd0, fault, cause}, {29'd0, !exec_ok(at), exec_ok(at) ? 2'd0 : 2'd3});
      look(a, 1, 1);
      check((fault == !exec_ok(at)) && (cause == (exec_ok(at) ? 2'd0 : 2'd3)),
            $sformatf("R10 fetch with store flag attr %0d", at), {29'd0, fault, cause}, {29'd0, !exec_ok(at), exec_ok(at) ? 2'd0 : 2'd3});
    end
  endtask

  task automatic t_fault_pa();
    wr_tab(0, 6, 2, 15);
    look({3'd6, 29'h1FFFFFFF}, 0, 0);
    check(fault && pa_out == 32'd0, "R9 faulting address is zero", pa_out, 32'd0);
    look({3'd6, 29'h1FFFFFFF}, 1, 0);
    check(!fault && pa_out == {3'd6, 29'h1FFFFFFF}, "R7 instruction side of region 6 intact", pa_out, {3'd6, 29'h1FFFFFFF});
  endtask

  initial begin
    rst = 1; acc_addr = 0; acc_fetch = 0; acc_write = 0;
    itab_wr_en = 0; itab_wr_idx = 0; itab_wr_base = 0; itab_wr_attr = 0;
    dtab_wr_en = 0; dtab_wr_idx = 0; dtab_wr_base = 0; dtab_wr_attr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset_map();
    t_write_timing();
    t_remap_and_sides();
    t_attr_sweep();
    t_fault_pa();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule